// File: doc/BRIEF.md
# Coarse Quantizer Trip-Point Calibration Sequencer

This block runs once after power-up to calibrate a small coarse flash quantizer whose comparators are deliberately undersized and therefore carry large random offsets. The bank is built with three times as many comparators as transitions. The sequencer steers a 10-bit search DAC into the comparator inputs and reads back one decision bit per comparator. For each of the seven coarse transitions it looks for a comparator whose trip point sits close to the ideal level. When it finds one, it stores that comparator's index and its exact trip point as a DAC code. When all seven are stored, it leaves an enable mask that keeps only the chosen comparators powered.

The search for a transition begins with one DAC sample at the ideal level. It then probes a window that is symmetric about that level. The window starts one DAC step wide on each side and grows by one step each time no comparator crosses inside it. A comparator that has already been chosen for an earlier transition is never chosen again. Any comparator may serve any transition, so a part whose offset moved it into a neighbour's range is reassigned there. The sample taken at the ideal level tells which edge of the window the crossing lies on, so the stored trip point is the exact DAC code and not the window centre.

Top module: `coarse_trip_search`

## Requirements
- R1: After a synchronous active-low reset, `dac_code` is 0, `busy`, `done` and `fail` are 0, `cmp_en` is all ones, and every field of `trip_idx` and `trip_code` is 0.
- R2: A high `start` seen while idle begins a calibration: `busy` rises on the next cycle and `fail` clears on the same cycle. While `busy` is high, `start` has no effect on the sequence.
- R3: Transitions k = 1..7 are handled in order, and the ideal level of transition k is k*128. Each transition drives the ideal level, then ideal−d, then ideal+d, for d = 1, 2, ..., and d restarts at 1 for each new transition. Each level is held for `settle_cycles`+1 cycles before the decisions are sampled. The ideal+d level stays on the DAC for one extra cycle while the sample is evaluated.
- R4: `cmp_out[i]` is 1 when the DAC code is at or above comparator i's trip point. Comparator i is a hit when its decision at ideal−d differs from its decision at ideal+d and it has not been chosen before. Of the hits, the lowest index is taken.
- R5: The stored trip code equals the smallest DAC code at which the chosen comparator reads 1.
- R6: Transition k has its comparator index in `trip_idx[(k-1)*5 +: 5]` and its trip code in `trip_code[(k-1)*10 +: 10]`.
- R7: `done` is high for exactly one cycle after the seventh record. `busy` is low in that same cycle.
- R8: `cmp_en` is all ones during a search. After `done`, exactly the seven chosen comparators have their enable bit set.
- R9: If d = 64 is evaluated without a hit, `fail` rises and `busy` falls with no `done` pulse, and `cmp_en` stays all ones. `fail` stays high until the next start.
- R10: While idle with `start` low, `dac_code` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Launch a calibration while idle |
| settle_cycles | input | 8 | Extra wait cycles after each DAC step before sampling |
| cmp_out | input | 21 | Decision of each redundant comparator |
| dac_code | output | 10 | Search DAC setting |
| busy | output | 1 | Calibration in progress |
| done | output | 1 | One-cycle pulse when all seven transitions are stored |
| fail | output | 1 | Sticky flag: a transition found no comparator within the maximum window |
| cmp_en | output | 21 | Comparator power enables |
| trip_idx | output | 35 | Chosen comparator index per transition, 5 bits each |
| trip_code | output | 70 | Measured trip DAC code per transition, 10 bits each |

## Verification
The edge that accepts `start` loads the first ideal level, and that level is visible from the following cycle. Each level then lasts `settle_cycles`+1 cycles, and the high probe lasts one more. The `done` or `fail` result, the records and the final enable mask all appear one cycle after the last high probe ends. The reference model walks the same schedule one clock at a time, working from comparator thresholds held in the bench. All comparisons are made at the falling edge, so every registered change from the preceding rising edge has settled. The stored trip codes are compared with the bench's own thresholds, not with anything taken from the sequencer.

// File: rtl/tsrch_pkg.sv
// Shared types for the coarse trip-point search sequencer.
// Assumes: nothing beyond IEEE 1800-2017 enum support.
package tsrch_pkg;

    // Top-level control states
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_EVAL = 2'd2
    } tsrch_state_t;

    // Which DAC level of the current window is being settled
    typedef enum logic [1:0] {
        PH_MID = 2'd0,
        PH_LO  = 2'd1,
        PH_HI  = 2'd2
    } tsrch_phase_t;

endpackage

// File: rtl/tsrch_settle_timer.sv
// Settle timer: counts cycles after each DAC load and flags when the
// programmed settle count has elapsed.
// Assumes: limit is stable while run is high; restart has priority.
module tsrch_settle_timer #(
    parameter int SET_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             run,
    input  logic [SET_W-1:0] limit,
    output logic             expired
);

    logic [SET_W-1:0] cnt_q;

    // Expiry when the wait has covered limit+1 cycles
    always_comb begin
        expired = run && (cnt_q == limit);
    end

    // Count up while waiting, clear on each new DAC level
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart) begin
            cnt_q <= '0;
        end else if (run && !expired) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/tsrch_lowest_pick.sv
// Lowest-index picker: from a candidate vector returns whether any bit is
// set, the one-hot of the lowest set bit, and its binary index.
// Assumes: IDX_W is wide enough to encode N-1.
module tsrch_lowest_pick #(
    parameter int N     = 21,
    parameter int IDX_W = 5
) (
    input  logic [N-1:0]     cand,
    output logic             found,
    output logic [N-1:0]     onehot,
    output logic [IDX_W-1:0] idx
);

    logic [N:0] below_any;

    assign below_any[0] = 1'b0;

    // Ripple a "some lower bit is set" chain and mask each candidate with it
    for (genvar g = 0; g < N; g++) begin : g_chain
        assign below_any[g+1] = below_any[g] | cand[g];
        assign onehot[g]      = cand[g] & ~below_any[g];
    end

    assign found = below_any[N];

    // Encode the one-hot winner into a binary index
    always_comb begin
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (onehot[i]) begin
                idx = idx | IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/tsrch_trip_store.sv
// Trip record store: one index/code register pair per coarse transition,
// cleared at the start of a run and written once per found transition.
// Assumes: wr_slot < SLOTS whenever wr_en is high.
module tsrch_trip_store #(
    parameter int SLOTS  = 7,
    parameter int IDX_W  = 5,
    parameter int CODE_W = 10,
    parameter int SLOT_W = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clear,
    input  logic                    wr_en,
    input  logic [SLOT_W-1:0]       wr_slot,
    input  logic [IDX_W-1:0]        wr_idx,
    input  logic [CODE_W-1:0]       wr_code,
    output logic [SLOTS*IDX_W-1:0]  idx_flat,
    output logic [SLOTS*CODE_W-1:0] code_flat
);

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        logic [IDX_W-1:0]  idx_q;
        logic [CODE_W-1:0] code_q;

        // Hold the record of transition s+1
        always_ff @(posedge clk) begin
            if (!rst_n || clear) begin
                idx_q  <= '0;
                code_q <= '0;
            end else if (wr_en && (wr_slot == SLOT_W'(s))) begin
                idx_q  <= wr_idx;
                code_q <= wr_code;
            end
        end

        assign idx_flat[s*IDX_W +: IDX_W]    = idx_q;
        assign code_flat[s*CODE_W +: CODE_W] = code_q;
    end

endmodule

// File: rtl/coarse_trip_search.sv
// Coarse trip-point search sequencer. For each coarse transition in turn it
// samples the comparator bank at the ideal level, then probes a symmetric
// window that widens by one DAC step per miss. It takes the lowest-index
// unchosen comparator that flips inside the window, stores its index and
// exact trip code, and leaves only the chosen comparators enabled.
// Assumes: cmp_out is a function of dac_code that is valid settle_cycles+1
// cycles after a DAC change; each comparator reads 1 at or above its trip.
module coarse_trip_search
    import tsrch_pkg::*;
#(
    parameter int NUM_CMP   = 21,
    parameter int NUM_TRANS = 7,
    parameter int DAC_W     = 10,
    parameter int MAX_DELTA = 64,
    parameter int SET_W     = 8
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   start,
    input  logic [SET_W-1:0]                       settle_cycles,
    input  logic [NUM_CMP-1:0]                     cmp_out,
    output logic [DAC_W-1:0]                       dac_code,
    output logic                                   busy,
    output logic                                   done,
    output logic                                   fail,
    output logic [NUM_CMP-1:0]                     cmp_en,
    output logic [NUM_TRANS*$clog2(NUM_CMP)-1:0]   trip_idx,
    output logic [NUM_TRANS*DAC_W-1:0]             trip_code
);

    localparam int IDX_W   = $clog2(NUM_CMP);
    localparam int SLOT_W  = $clog2(NUM_TRANS);
    localparam int DELTA_W = $clog2(MAX_DELTA + 1);
    localparam int STEP    = (2 ** DAC_W) / (NUM_TRANS + 1);
    localparam int WIDE_W  = DAC_W + 1;
    localparam logic [SLOT_W-1:0]  LAST_SLOT = SLOT_W'(NUM_TRANS - 1);
    localparam logic [DELTA_W-1:0] TOP_DELTA = DELTA_W'(MAX_DELTA);

    tsrch_state_t state_q;
    tsrch_phase_t phase_q;
    logic [SLOT_W-1:0]  slot_q;
    logic [DELTA_W-1:0] delta_q;
    logic [DAC_W-1:0]   dac_q;
    logic [NUM_CMP-1:0] mid_q, lo_q, hi_q, taken_q, en_q;
    logic               done_q, fail_q;

    logic               tmr_exp, dac_load;
    logic [NUM_CMP-1:0] cand, pk_onehot;
    logic               pk_found;
    logic [IDX_W-1:0]   pk_idx;
    logic [WIDE_W-1:0]  ideal_w, delta_w, step_lo, step_hi, wide_lo, trip_w;
    logic               rec_en, last_hit, out_of_room;

    // Ideal DAC level of transition slot+1
    function automatic logic [WIDE_W-1:0] ideal_of(input logic [SLOT_W-1:0] s);
        return WIDE_W'((int'(s) + 1) * STEP);
    endfunction

    // Window edges for the present and the next wider window
    always_comb begin
        ideal_w = ideal_of(slot_q);
        delta_w = WIDE_W'(delta_q);
        step_lo = ideal_w - delta_w;
        step_hi = ideal_w + delta_w;
        wide_lo = ideal_w - delta_w - WIDE_W'(1);
    end

    // Candidates flip between the low and high probe and are still free
    always_comb begin
        cand = (lo_q ^ hi_q) & ~taken_q;
    end

    tsrch_lowest_pick #(
        .N     (NUM_CMP),
        .IDX_W (IDX_W)
    ) u_pick (
        .cand   (cand),
        .found  (pk_found),
        .onehot (pk_onehot),
        .idx    (pk_idx)
    );

    // Exact trip: ideal-level decision tells which window edge crossed
    always_comb begin
        trip_w = mid_q[pk_idx] ? (step_lo + WIDE_W'(1)) : step_hi;
    end

    // Evaluation outcomes and the DAC-load strobe for the settle timer
    always_comb begin
        rec_en      = (state_q == ST_EVAL) && pk_found;
        last_hit    = rec_en && (slot_q == LAST_SLOT);
        out_of_room = (state_q == ST_EVAL) && !pk_found && (delta_q == TOP_DELTA);
        dac_load    = ((state_q == ST_IDLE) && start)
                    || ((state_q == ST_WAIT) && tmr_exp && (phase_q != PH_HI))
                    || ((state_q == ST_EVAL) && !last_hit && !out_of_room);
    end

    tsrch_settle_timer #(
        .SET_W (SET_W)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (dac_load),
        .run     (state_q == ST_WAIT),
        .limit   (settle_cycles),
        .expired (tmr_exp)
    );

    tsrch_trip_store #(
        .SLOTS  (NUM_TRANS),
        .IDX_W  (IDX_W),
        .CODE_W (DAC_W),
        .SLOT_W (SLOT_W)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     ((state_q == ST_IDLE) && start),
        .wr_en     (rec_en),
        .wr_slot   (slot_q),
        .wr_idx    (pk_idx),
        .wr_code   (trip_w[DAC_W-1:0]),
        .idx_flat  (trip_idx),
        .code_flat (trip_code)
    );

    // Sequence control: step DAC levels, sample decisions, evaluate windows
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            phase_q <= PH_MID;
            slot_q  <= '0;
            delta_q <= DELTA_W'(1);
            dac_q   <= '0;
            mid_q   <= '0;
            lo_q    <= '0;
            hi_q    <= '0;
            taken_q <= '0;
            en_q    <= '1;
            done_q  <= 1'b0;
            fail_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        slot_q  <= '0;
                        delta_q <= DELTA_W'(1);
                        taken_q <= '0;
                        en_q    <= '1;
                        fail_q  <= 1'b0;
                        phase_q <= PH_MID;
                        dac_q   <= ideal_of('0)[DAC_W-1:0];
                        state_q <= ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (tmr_exp) begin
                        unique case (phase_q)
                            PH_MID: begin
                                mid_q   <= cmp_out;
                                dac_q   <= step_lo[DAC_W-1:0];
                                phase_q <= PH_LO;
                            end
                            PH_LO: begin
                                lo_q    <= cmp_out;
                                dac_q   <= step_hi[DAC_W-1:0];
                                phase_q <= PH_HI;
                            end
                            default: begin
                                hi_q    <= cmp_out;
                                state_q <= ST_EVAL;
                            end
                        endcase
                    end
                end
                default: begin
                    if (pk_found) begin
                        taken_q <= taken_q | pk_onehot;
                        if (last_hit) begin
                            en_q    <= taken_q | pk_onehot;
                            done_q  <= 1'b1;
                            state_q <= ST_IDLE;
                        end else begin
                            slot_q  <= slot_q + 1'b1;
                            delta_q <= DELTA_W'(1);
                            dac_q   <= ideal_of(slot_q + 1'b1)[DAC_W-1:0];
                            phase_q <= PH_MID;
                            state_q <= ST_WAIT;
                        end
                    end else if (out_of_room) begin
                        fail_q  <= 1'b1;
                        state_q <= ST_IDLE;
                    end else begin
                        delta_q <= delta_q + 1'b1;
                        dac_q   <= wide_lo[DAC_W-1:0];
                        phase_q <= PH_LO;
                        state_q <= ST_WAIT;
                    end
                end
            endcase
        end
    end

    assign dac_code = dac_q;
    assign busy     = (state_q != ST_IDLE);
    assign done     = done_q;
    assign fail     = fail_q;
    assign cmp_en   = en_q;

endmodule

// File: rtl/coarse_trip_search_chk.sv
// Checker for coarse_trip_search: temporal rules on the sequencer ports.
// Assumes: attached through the bind below, same clock and reset.
module coarse_trip_search_chk #(
    parameter int NUM_CMP   = 21,
    parameter int NUM_TRANS = 7,
    parameter int DAC_W     = 10,
    parameter int MAX_DELTA = 64
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start,
    input logic               busy,
    input logic               done,
    input logic               fail,
    input logic [DAC_W-1:0]   dac_code,
    input logic [NUM_CMP-1:0] cmp_en
);

    localparam int STEP   = (2 ** DAC_W) / (NUM_TRANS + 1);
    localparam int LOWEST = STEP - MAX_DELTA;
    localparam int UPPER  = NUM_TRANS * STEP + MAX_DELTA;

    // R2
    start_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> (busy && !fail));

    // R3
    dac_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (int'(dac_code) >= LOWEST && int'(dac_code) <= UPPER));

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy && !fail);

    // R8
    search_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (cmp_en == {NUM_CMP{1'b1}}));

    // R8
    final_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($countones(cmp_en) == NUM_TRANS));

    // R9
    fail_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fail |-> (!busy && cmp_en == {NUM_CMP{1'b1}}));

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(dac_code));

endmodule

bind coarse_trip_search coarse_trip_search_chk #(
    .NUM_CMP   (NUM_CMP),
    .NUM_TRANS (NUM_TRANS),
    .DAC_W     (DAC_W),
    .MAX_DELTA (MAX_DELTA)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .fail     (fail),
    .dac_code (dac_code),
    .cmp_en   (cmp_en)
);

// File: tb/sim_coarse_trip_search.sv
// Bench: comparator bank modelled as thresholds; a procedural reference
// walks the expected DAC schedule and is compared at every falling edge.
module sim_coarse_trip_search;

    localparam int NC = 21;
    localparam int NT = 7;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [7:0]    settle = 8'd2;
    logic [NC-1:0] cmp_vec;
    logic [9:0]    dac_code;
    logic          busy, done, fail;
    logic [NC-1:0] cmp_en;
    logic [34:0]   trip_idx;
    logic [69:0]   trip_code;

    int thr[NC];
    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    // Ideal comparators: 1 at or above the threshold
    always_comb begin
        for (int i = 0; i < NC; i++) cmp_vec[i] = (int'(dac_code) >= thr[i]);
    end

    coarse_trip_search u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .start         (start),
        .settle_cycles (settle),
        .cmp_out       (cmp_vec),
        .dac_code      (dac_code),
        .busy          (busy),
        .done          (done),
        .fail          (fail),
        .cmp_en        (cmp_en),
        .trip_idx      (trip_idx),
        .trip_code     (trip_code)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    // Expect one DAC level for n falling edges while searching
    task automatic show(input int v, input int n, input bit hold);
        repeat (n) begin
            @(negedge clk);
            start = hold;
            chk(int'(dac_code) == v, "R3 dac level", int'(dac_code), v);
            chk(busy && !done && !fail && cmp_en == '1, "R8 search flags",
                int'({busy, done, fail}), 4);
            @(posedge clk);
        end
    endtask

    // Launch one calibration and follow it cycle by cycle
    task automatic run_cal(input int s, input bit hold, input bit want_fail);
        int picks[NT];
        logic [NC-1:0] taken = '0;
        bit failed = 0;
        int done_k = 0;
        settle = 8'(s);
        @(negedge clk);
        start = 1'b1;
        @(posedge clk);
        for (int k = 0; k < NT; k++) begin
            int ideal = (k + 1) * 128;
            int d = 1;
            show(ideal, s + 1, hold);
            forever begin
                int pick = -1;
                show(ideal - d, s + 1, hold);
                show(ideal + d, s + 2, hold);
                for (int i = 0; i < NC; i++) begin
                    if (pick < 0 && !taken[i] &&
                        ((ideal - d >= thr[i]) != (ideal + d >= thr[i]))) pick = i;
                end
                if (pick >= 0) begin
                    taken[pick] = 1'b1;
                    picks[k] = pick;
                    done_k = k + 1;
                    break;
                end
                if (d == 64) begin
                    failed = 1;
                    break;
                end
                d++;
            end
            if (failed) break;
        end
        @(negedge clk);
        start = 1'b0;
        chk(failed == want_fail, "R9 scenario outcome", int'(failed), int'(want_fail));
        if (!failed) begin
            chk(done && !busy && !fail, "R7 done pulse", int'({done, busy, fail}), 4);
            chk(cmp_en == taken, "R8 final mask", int'(cmp_en), int'(taken));
            for (int k = 0; k < NT; k++) begin
                chk(int'(trip_idx[k*5 +: 5]) == picks[k], "R4 R6 chosen index",
                    int'(trip_idx[k*5 +: 5]), picks[k]);
                chk(int'(trip_code[k*10 +: 10]) == thr[picks[k]], "R5 R6 trip code",
                    int'(trip_code[k*10 +: 10]), thr[picks[k]]);
            end
        end else begin
            chk(fail && !busy && !done, "R9 fail flag", int'({fail, busy, done}), 4);
            chk(cmp_en == '1, "R9 enables kept", int'(cmp_en), (1 << NC) - 1);
            for (int k = 0; k < done_k; k++) begin
                chk(int'(trip_code[k*10 +: 10]) == thr[picks[k]], "R5 partial record",
                    int'(trip_code[k*10 +: 10]), thr[picks[k]]);
            end
        end
        @(negedge clk);
        chk(!done, "R7 done single cycle", int'(done), 0);
        chk(fail == failed, "R9 fail sticky", int'(fail), int'(failed));
    endtask

    // Watchdog: a hung run is a failed check and still prints the summary
    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired act=1 exp=0");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < NC; i++) thr[i] = 1023;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk(dac_code == 0 && !busy && !done && !fail, "R1 reset outputs",
            int'({busy, done, fail}), 0);
        chk(cmp_en == '1, "R1 reset enables", int'(cmp_en), (1 << NC) - 1);
        chk(trip_idx == '0 && trip_code == '0, "R1 reset records", int'(trip_code[9:0]), 0);
        rst_n = 1'b1;
        repeat (4) begin
            @(negedge clk);
            chk(dac_code == 0 && !busy, "R10 idle hold", int'(dac_code), 0);
        end

        // Exact thresholds: the first of each group wins at the first window
        for (int i = 0; i < NC; i++) thr[i] = (i / 3 + 1) * 128;
        run_cal(2, 0, 0);
        chk(cmp_en == 21'h49249, "R8 directed mask", int'(cmp_en), 'h49249);
        chk(trip_code[9:0] == 10'd128, "R5 directed trip", int'(trip_code[9:0]), 128);
        repeat (3) begin
            @(negedge clk);
            chk(dac_code == 10'd897 && !busy, "R10 idle after done", int'(dac_code), 897);
        end

        // Widening and reassignment, zero settle
        for (int i = 0; i < NC; i++) thr[i] = (i / 3 + 1) * 128 + 40;
        thr[0] = 131; thr[1] = 126; thr[2] = 200;
        thr[5] = 250;
        run_cal(0, 0, 0);
        chk(trip_idx[4:0] == 5'd0 && trip_code[9:0] == 10'd131, "R4 window of three",
            int'(trip_code[9:0]), 131);
        chk(trip_idx[9:5] == 5'd5, "R4 reassigned comparator", int'(trip_idx[9:5]), 5);

        // Random offsets, long settle, start held high throughout (R2)
        for (int i = 0; i < NC; i++) thr[i] = (i / 3 + 1) * 128 + $urandom_range(48) - 24;
        run_cal(5, 1, 0);

        // No comparator near transition 4: exhaustion
        for (int i = 0; i < NC; i++) thr[i] = (i < 9) ? (i / 3 + 1) * 128 : 1023;
        run_cal(1, 0, 1);

        // Restart after failure with new random offsets
        for (int i = 0; i < NC; i++) thr[i] = (i / 3 + 1) * 128 + $urandom_range(30) - 15;
        run_cal(3, 0, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule